// File: doc/BRIEF.md
# LIN Master Header Generator

This block drives the header of a LIN master frame onto one transmit line. A single start request launches a fixed sequence: a low break whose length is counted by a dedicated break timer, a one-bit high delimiter, the synchronisation byte 0x55, and then the identifier byte supplied by software. Both bytes go out in plain UART framing, and every bit lasts a programmable number of clock cycles.

The break timer behaves like a small general-purpose timer. The sequencer sets its run-control bit when the break begins and clears it when the break is over. The timer reports a running-status flag that follows the control bit with a lag of one bit tick in each direction. When the break ends, a sticky break-done flag is raised after a short synchronisation delay, so software can poll it. A one-cycle interrupt pulse is raised in the same cycle as the flag, for software that does not poll. A one-cycle done pulse marks the end of the identifier byte. Software clears the break-done flag by writing one to it.

Top module: `lin_hdr_gen`

## Requirements
- R1: After reset, and whenever no header is in progress, `tx_o` is 1 and `busy_o` is 0. After reset, `brk_run_o`, `brk_done_o`, `brk_irq_o` and `hdr_done_o` are 0.
- R2: If `start_i` is 1 in an idle cycle, `tx_o` goes to 0 in the next cycle and stays 0 for exactly L×D cycles. L is the break length in bit times and D is the bit period in clocks, both captured from the inputs in that cycle.
- R3: After the break, `tx_o` is 1 for one bit time (the delimiter). The byte 0x55 then follows as ten bit times: a start bit of 0, data bits 0 to 7 least significant first, and a stop bit of 1.
- R4: The identifier byte `id_i`, captured in the start cycle, follows the synch stop bit with no gap, in the same ten-bit framing.
- R5: `brk_run_o` becomes 1 exactly D cycles after the break begins (at the first bit tick). It returns to 0 exactly one bit time after `tx_o` rises at the end of the break.
- R6: `brk_done_o` becomes 1 two cycles after `tx_o` rises at the end of the break. It stays 1 until `brk_clr_i` is 1. If a clear arrives in the same cycle the flag is being set, the set wins.
- R7: `brk_irq_o` is a one-cycle pulse in the cycle that `brk_done_o` is set.
- R8: `start_i` has no effect while `busy_o` is 1. Changes to `id_i`, `brk_len_i` and `bit_div_i` after the start cycle have no effect on the header in flight.
- R9: `hdr_done_o` is a one-cycle pulse (L+21)×D cycles after the break begins, at the end of the identifier stop bit. `busy_o` is 0 in that cycle.
- R10: `brk_len_i` = 0 selects the default break length of 13 bit times. A `bit_div_i` below 2 is treated as 2 clocks per bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one header (sampled when idle) |
| id_i | input | 8 | Protected identifier byte |
| brk_len_i | input | LEN_W | Break length in bit times, 0 selects the default |
| bit_div_i | input | DIV_W | Clocks per bit |
| brk_clr_i | input | 1 | Write-one-to-clear for the break-done flag |
| tx_o | output | 1 | Serial transmit line, idle high |
| busy_o | output | 1 | Header in progress |
| brk_run_o | output | 1 | Break timer running-status flag |
| brk_done_o | output | 1 | Sticky break-done flag |
| brk_irq_o | output | 1 | Break-done interrupt pulse |
| hdr_done_o | output | 1 | Pulse at the end of the identifier stop bit |

## Verification
The break-done flag can be set by the end of a break in the same cycle that software writes one to clear it. In one header the bench holds `brk_clr_i` high for exactly the cycle whose edge sets the flag. It then expects the flag to read 1 and the interrupt to pulse, and checks that a clear in a later cycle does take effect. In every header the bench also raises a new start request, with a different identifier and different settings, in the middle of the header. The scoreboard then judges every transmitted bit against the frame expected from the original request.

// File: rtl/lin_hdr_pkg.sv
// Shared types and constants for the LIN master header generator.
package lin_hdr_pkg;

    // Sequencer phases of one header.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BRK   = 3'd1,
        ST_DELIM = 3'd2,
        ST_SYNC  = 3'd3,
        ST_IDB   = 3'd4
    } hdr_state_t;

    localparam logic [7:0] SYNC_BYTE  = 8'h55;
    localparam int         FRAME_BITS = 10;   // start + 8 data + stop

endpackage

// File: rtl/lin_bit_clk.sv
// Bit-period tick generator.
// Produces a one-cycle tick every div_i clocks while en_i is high and
// restarts from zero when en_i is low. Assumes div_i >= 2 (the caller clamps it).
module lin_bit_clk #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == div_i - DIV_W'(1));

    // Count clocks within the current bit; wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R10: the counter never runs past the clamped divider.
    assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q < div_i));

endmodule

// File: rtl/lin_brk_timer.sv
// Break-length timer.
// Counts bit ticks while the run-control input is high and flags the tick
// that completes len_i bit times. Its running-status flag follows the
// control input one count-source tick late. Assumes len_i >= 1.
module lin_brk_timer #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_ctl_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             brk_end_o,
    output logic             run_o
);

    logic [LEN_W-1:0] cnt_q;
    logic             run_q;

    assign brk_end_o = run_ctl_i && tick_i && (cnt_q == len_i - LEN_W'(1));
    assign run_o     = run_q;

    // Count elapsed break bit times; hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_ctl_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    // Status flag takes the control value on each count-source tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (tick_i) begin
            run_q <= run_ctl_i;
        end
    end

    // R5: the status flag changes only on a count-source tick.
    assert_run_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_q) || $fell(run_q)) |-> $past(tick_i));

endmodule

// File: rtl/lin_brk_status.sv
// Break-done status.
// Delays the break-end event through two stages, then sets a sticky flag
// and fires a one-cycle interrupt. The flag is cleared by a write-one
// pulse; a set in the same cycle wins.
module lin_brk_status (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_end_i,
    input  logic clr_i,
    output logic flag_o,
    output logic irq_o
);

    logic [1:0] dly_q;
    logic       flag_q;
    logic       irq_q;

    assign flag_o = flag_q;
    assign irq_o  = irq_q;

    // Two-stage lag from break end to flag set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else begin
            dly_q <= {dly_q[0], brk_end_i};
        end
    end

    // Sticky flag with write-one-to-clear; setting has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (dly_q[1]) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt pulse coincides with the flag being set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= dly_q[1];
        end
    end

    // R6: the flag rises exactly three edges after the break-end event.
    assert_flag_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(brk_end_i, 3));

    // R7: the interrupt is a single-cycle pulse.
    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

endmodule

// File: rtl/lin_hdr_gen.sv
// LIN master header generator (top).
// On a start request in idle, captures the identifier, break length and
// bit divider, then drives break, delimiter, 0x55 and the identifier in
// UART framing on tx_o. Start requests while busy are ignored.
module lin_hdr_gen
    import lin_hdr_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int LEN_W   = 6,
    parameter int DEF_BRK = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       id_i,
    input  logic [LEN_W-1:0] brk_len_i,
    input  logic [DIV_W-1:0] bit_div_i,
    input  logic             brk_clr_i,
    output logic             tx_o,
    output logic             busy_o,
    output logic             brk_run_o,
    output logic             brk_done_o,
    output logic             brk_irq_o,
    output logic             hdr_done_o
);

    localparam int         BITN_W    = $clog2(FRAME_BITS);
    localparam logic [BITN_W-1:0] LAST_BIT = BITN_W'(FRAME_BITS - 1);
    localparam logic [DIV_W-1:0]  MIN_DIV  = DIV_W'(2);

    hdr_state_t        state_q;
    logic              tx_q;
    logic              run_ctl_q;
    logic              done_q;
    logic [7:0]        id_q;
    logic [LEN_W-1:0]  len_q;
    logic [DIV_W-1:0]  div_q;
    logic [8:0]        sh_q;
    logic [BITN_W-1:0] bitn_q;
    logic              tick;
    logic              brk_end;

    assign tx_o       = tx_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign hdr_done_o = done_q;

    lin_bit_clk #(.DIV_W(DIV_W)) bit_clk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy_o),
        .div_i  (div_q),
        .tick_o (tick)
    );

    lin_brk_timer #(.LEN_W(LEN_W)) brk_timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .run_ctl_i (run_ctl_q),
        .len_i     (len_q),
        .brk_end_o (brk_end),
        .run_o     (brk_run_o)
    );

    lin_brk_status brk_status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_end_i (brk_end),
        .clr_i     (brk_clr_i),
        .flag_o    (brk_done_o),
        .irq_o     (brk_irq_o)
    );

    // Header sequencer: phase control, bit serialiser and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tx_q      <= 1'b1;
            run_ctl_q <= 1'b0;
            done_q    <= 1'b0;
            id_q      <= '0;
            len_q     <= LEN_W'(DEF_BRK);
            div_q     <= MIN_DIV;
            sh_q      <= '0;
            bitn_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q   <= ST_BRK;
                        tx_q      <= 1'b0;
                        run_ctl_q <= 1'b1;
                        id_q      <= id_i;
                        len_q     <= (brk_len_i == '0) ? LEN_W'(DEF_BRK) : brk_len_i;
                        div_q     <= (bit_div_i < MIN_DIV) ? MIN_DIV : bit_div_i;
                    end
                end
                ST_BRK: begin
                    if (brk_end) begin
                        state_q   <= ST_DELIM;
                        tx_q      <= 1'b1;
                        run_ctl_q <= 1'b0;
                    end
                end
                ST_DELIM: begin
                    if (tick) begin
                        state_q <= ST_SYNC;
                        tx_q    <= 1'b0;
                        sh_q    <= {1'b1, SYNC_BYTE};
                        bitn_q  <= '0;
                    end
                end
                ST_SYNC, ST_IDB: begin
                    if (tick) begin
                        if (bitn_q == LAST_BIT) begin
                            if (state_q == ST_SYNC) begin
                                state_q <= ST_IDB;
                                tx_q    <= 1'b0;
                                sh_q    <= {1'b1, id_q};
                                bitn_q  <= '0;
                            end else begin
                                state_q <= ST_IDLE;
                                tx_q    <= 1'b1;
                                done_q  <= 1'b1;
                            end
                        end else begin
                            tx_q   <= sh_q[0];
                            sh_q   <= {1'b0, sh_q[8:1]};
                            bitn_q <= bitn_q + BITN_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: the line idles high whenever no header is in progress.
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);

    // R2: the line is held low while the break timer is running.
    assert_brk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_ctl_q |-> !tx_o);

    // R8: a start request while busy leaves the captured identifier alone.
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(id_q));

    // R9: the header-done indication is a single-cycle pulse outside busy.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done_o |-> (!busy_o ##1 !hdr_done_o));

endmodule

// File: tb/lin_hdr_gen_tb_top.sv
`timescale 1ns/1ps
module lin_hdr_gen_tb_top;

    localparam int DIV_W = 16;
    localparam int LEN_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [7:0]       id_i = 8'h00;
    logic [LEN_W-1:0] brk_len_i = '0;
    logic [DIV_W-1:0] bit_div_i = '0;
    logic             brk_clr_i = 1'b0;
    logic             tx_o, busy_o, brk_run_o, brk_done_o, brk_irq_o, hdr_done_o;

    int n_chk = 0;
    int n_err = 0;

    typedef struct { int div; int nbits; } hdr_t;
    hdr_t hdr_q[$];
    logic exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    lin_hdr_gen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .id_i(id_i),
        .brk_len_i(brk_len_i), .bit_div_i(bit_div_i), .brk_clr_i(brk_clr_i),
        .tx_o(tx_o), .busy_o(busy_o), .brk_run_o(brk_run_o),
        .brk_done_o(brk_done_o), .brk_irq_o(brk_irq_o), .hdr_done_o(hdr_done_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_frame(input logic [7:0] b);
        exp_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
        exp_q.push_back(1'b1);
    endtask

    // Driver: pushes the expected line levels, then launches and follows one header.
    task automatic run_header(input logic [7:0] id, input int len_in, input int div_in,
                              input int L, input int D, input bit collide);
        hdr_t h;
        int end_cyc;
        h.div = D; h.nbits = L + 21;
        for (int i = 0; i < L; i++) exp_q.push_back(1'b0);   // R2 break
        exp_q.push_back(1'b1);                                // R3 delimiter
        push_frame(8'h55);                                    // R3 synch byte
        push_frame(id);                                       // R4 identifier
        hdr_q.push_back(h);
        @(negedge clk);
        id_i = id; brk_len_i = LEN_W'(len_in); bit_div_i = DIV_W'(div_in); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R8: settings changed after the start cycle must not matter
        id_i = ~id; brk_len_i = LEN_W'(L + 5); bit_div_i = DIV_W'(D + 3);
        end_cyc = (L + 21) * D;
        for (int c = 0; c <= end_cyc; c++) begin
            if (c == 0)               check("R8 busy after start", busy_o, 1);
            if (c == D - 1)           check("R5 run flag before first tick", brk_run_o, 0);
            if (c == D)               check("R5 run flag at first tick", brk_run_o, 1);
            if (c == (L + 1) * D - 1) check("R5 run flag before stop lag", brk_run_o, 1);
            if (c == (L + 1) * D)     check("R5 run flag after stop lag", brk_run_o, 0);
            if (c == L * D + 1) begin
                check("R6 done flag one cycle after break", brk_done_o, 0);
                if (collide) brk_clr_i = 1'b1;
            end
            if (c == L * D + 2) begin
                brk_clr_i = 1'b0;
                check("R6 done flag two cycles after break", brk_done_o, 1);
                check("R7 irq with flag", brk_irq_o, 1);
            end
            if (c == L * D + 3)       check("R7 irq single pulse", brk_irq_o, 0);
            if (c == 5 * D) begin
                start_i = 1'b1; id_i = 8'hC3;   // R8 start while busy
            end
            if (c == 5 * D + 1)       start_i = 1'b0;
            if (c == end_cyc - 1)     check("R9 no early done", hdr_done_o, 0);
            if (c == end_cyc) begin
                check("R9 done pulse", hdr_done_o, 1);
                check("R9 busy low at done", busy_o, 0);
                check("R6 flag sticky through header", brk_done_o, 1);
            end
            if (c != end_cyc) @(negedge clk);
        end
        @(negedge clk);
        check("R9 done pulse width", hdr_done_o, 0);
        check("R1 idle line high", tx_o, 1);
        brk_clr_i = 1'b1;
        @(negedge clk);
        brk_clr_i = 1'b0;
        check("R6 write-one clears flag", brk_done_o, 0);
    endtask

    // Monitor: samples every bit mid-period and compares against the scoreboard.
    initial begin
        forever begin
            hdr_t h;
            wait (hdr_q.size() > 0);
            h = hdr_q.pop_front();
            do @(negedge clk); while (tx_o !== 1'b0);
            repeat (h.div / 2) @(negedge clk);
            for (int b = 0; b < h.nbits; b++) begin
                logic e;
                e = exp_q.pop_front();
                check($sformatf("R2/R3/R4 bit %0d", b), int'(tx_o), int'(e));
                if (b != h.nbits - 1) repeat (h.div) @(negedge clk);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired (R9 header never completed)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset tx", tx_o, 1);
        check("R1 reset busy", busy_o, 0);
        check("R1 reset run flag", brk_run_o, 0);
        check("R1 reset done flag", brk_done_o, 0);
        check("R1 reset irq", brk_irq_o, 0);
        check("R1 reset hdr done", hdr_done_o, 0);
        run_header(8'h3C, 13, 4, 13, 4, 1'b0);
        run_header(8'hA5, 0, 6, 13, 6, 1'b0);    // R10 default break length
        run_header(8'h00, 1, 2, 1, 2, 1'b1);     // R6 set/clear collision
        run_header(8'hFF, 3, 0, 3, 2, 1'b1);     // R10 divider clamp
        run_header(8'h81, 20, 3, 20, 3, 1'b0);
        wait (exp_q.size() == 0);
        repeat (10) @(negedge clk);
        check("R1 final idle", tx_o, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule